// File: doc/BRIEF.md
# Register-Driven Atomic Read-Modify-Write Unit

This block gives software a load-linked / store-conditional style atomic update through plain register accesses instead of dedicated instructions. Software writes a word address into the address register. The unit then reads that word from memory over a single-word master port and places it in the data register. Software reads the data register, computes a new value, and writes it back into the data register. That write makes the unit try to store the value to the held address.

Between the fetch and the store, the unit watches four conditions, each with its own sticky flag:
- another master touching the same memory word,
- an asserted bus lock,
- a pending interrupt,
- a memory error on either transfer.

After the store attempt, software reads the status register. Any set flag means the update did not take effect atomically and must be retried. If a flag is already set when the data register is written, the unit issues no memory write at all. The unit keeps at most one operation in flight.

Top module: `atomreg_unit`

## Requirements
- R1: A write to offset 0x0 while idle starts a memory read of the addressed word. The read data lands in the data register (offset 0x4). Status bit 4 (busy) reads 1 from the cycle after the write until the memory port answers. The memory request, address and direction stay steady until the answer arrives.
- R2: A write to the address register clears status bits 0 to 3.
- R3: A write to offset 0x4 after a completed fetch issues one memory write of that value to the held address. The address register and all memory addresses are word aligned: bits 1:0 are forced to zero.
- R4: Status bit 0 (shared-access flag) sets when `snoop_valid` is seen with an address in the same word as the held address. The check runs between the end of the fetch and the data-register write. An access to a different word sets nothing.
- R5: Status bit 1 (lock flag) sets when `bus_lock` is high in that same window.
- R6: Status bit 2 (interrupt flag) sets when `irq_pend` is high in that same window.
- R7: Status bit 3 (error flag) sets when the memory port returns `mem_err` with its answer, on either the fetch or the store.
- R8: If any of status bits 0 to 3 is set when the data register is written, no memory write is issued and the data register keeps the fetched value.
- R9: A data-register write with no fetched word pending is ignored. This covers writes after reset and second writes after a store attempt. Such a write changes neither memory nor the data register.
- R10: Any register write made while busy is ignored.
- R11: Reads return the following:
  - offset 0x0: the held word address;
  - offset 0x4: the data register;
  - offset 0x8: `{busy, error, interrupt, lock, shared}` in bits 4:0, with the other bits zero.
  
  Writes to offset 0x8 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_sel | input | 1 | Register access strobe |
| reg_wr | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 4 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| mem_req | output | 1 | Memory request, held until `mem_done` |
| mem_we | output | 1 | 1 = store, 0 = fetch |
| mem_addr | output | 16 | Word-aligned memory byte address |
| mem_wdata | output | 32 | Store data |
| mem_done | input | 1 | One-cycle answer to a request |
| mem_rdata | input | 32 | Fetch data, valid with `mem_done` |
| mem_err | input | 1 | Error qualifier, valid with `mem_done` |
| snoop_valid | input | 1 | Another master accessed memory this cycle |
| snoop_addr | input | 16 | Byte address of that access |
| bus_lock | input | 1 | Bus lock asserted |
| irq_pend | input | 1 | Interrupt pending |

## Verification
The assertions rely on the memory port pulsing `mem_done` only while `mem_req` is high, and for exactly one cycle per request. The bench memory model guarantees this with a fixed two-cycle latency. That latency also lets a flag-clearing address write settle before any answer can arrive. The monitor inputs are pulsed for single cycles, and only while the unit is idle with a fetched word pending. The bench sweeps every word of an eight-word memory against every hazard case, using unaligned byte addresses so that alignment is exercised. It computes the expected flags, write counts and memory contents by arithmetic on the scenario number.

// File: rtl/atomreg_pkg.sv
package atomreg_pkg;
    localparam int OFS_ADDR = 0;
    localparam int OFS_DATA = 4;
    localparam int OFS_STAT = 8;
    localparam int NFLAG    = 4;
    localparam int F_SHARED = 0;
    localparam int F_LOCK   = 1;
    localparam int F_IRQ    = 2;
    localparam int F_ERR    = 3;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_FETCH = 2'd1,
        S_STORE = 2'd2
    } seq_state_e;
endpackage

// File: rtl/atomreg_regif.sv
module atomreg_regif
    import atomreg_pkg::*;
#(
    parameter int DW = 32,
    parameter int AW = 16,
    parameter int OW = 4
) (
    input  logic             reg_sel,
    input  logic             reg_wr,
    input  logic [OW-1:0]    reg_addr,
    input  logic             busy,
    input  logic [AW-1:0]    addr_q,
    input  logic [DW-1:0]    data_q,
    input  logic [NFLAG-1:0] flags,
    output logic             addr_go,
    output logic             data_go,
    output logic [DW-1:0]    reg_rdata
);
    localparam int SW = NFLAG + 1;

    logic wr_ok;

    always_comb begin
        wr_ok   = reg_sel && reg_wr && !busy;
        addr_go = wr_ok && (reg_addr == OW'(OFS_ADDR));
        data_go = wr_ok && (reg_addr == OW'(OFS_DATA));
        unique case (reg_addr)
            OW'(OFS_ADDR): reg_rdata = DW'(addr_q);
            OW'(OFS_DATA): reg_rdata = data_q;
            OW'(OFS_STAT): reg_rdata = DW'({busy, flags});
            default:       reg_rdata = '0;
        endcase
    end

    initial begin
        assert (DW >= AW && DW >= SW) else $error("register width too narrow");
    end
endmodule

// File: rtl/atomreg_watch.sv
module atomreg_watch
    import atomreg_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             window,
    input  logic [AW-1:0]    held_addr,
    input  logic             snoop_valid,
    input  logic [AW-1:0]    snoop_addr,
    input  logic             bus_lock,
    input  logic             irq_pend,
    input  logic             err_evt,
    output logic [NFLAG-1:0] flags
);
    localparam logic [AW-1:0] LOW_MASK = AW'(3);

    typedef struct packed {
        logic [NFLAG-1:0] flags;
    } watch_t;

    watch_t           st_d, st_q;
    logic [NFLAG-1:0] ev;
    logic             same_word;

    always_comb begin
        same_word    = (snoop_addr | LOW_MASK) == (held_addr | LOW_MASK);
        ev           = '0;
        ev[F_SHARED] = window && snoop_valid && same_word;
        ev[F_LOCK]   = window && bus_lock;
        ev[F_IRQ]    = window && irq_pend;
        ev[F_ERR]    = err_evt;
        st_d         = st_q;
        if (clr) st_d.flags = '0;
        else     st_d.flags = st_q.flags | ev;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flags = st_q.flags;

    // R5/R6: lock and interrupt flags cannot rise outside the window
    p_lock_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!window && !clr && !flags[F_LOCK]) |=> !flags[F_LOCK]);
    p_irq_window_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!window && !clr && !flags[F_IRQ]) |=> !flags[F_IRQ]);
endmodule

// File: rtl/atomreg_seq.sv
module atomreg_seq
    import atomreg_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          addr_go,
    input  logic          data_go,
    input  logic [DW-1:0] wdata,
    input  logic          flags_any,
    input  logic          mem_done,
    input  logic [DW-1:0] mem_rdata,
    input  logic          mem_err,
    output logic [AW-1:0] addr_q,
    output logic [DW-1:0] data_q,
    output logic          busy,
    output logic          armed,
    output logic          err_evt,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata
);
    typedef struct packed {
        seq_state_e    state;
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
        logic          armed;
    } seq_t;

    seq_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        err_evt = mem_done && mem_err && (st_q.state != S_IDLE);
        unique case (st_q.state)
            S_IDLE: begin
                if (addr_go) begin
                    st_d.addr  = {wdata[AW-1:2], 2'b00};
                    st_d.state = S_FETCH;
                    st_d.armed = 1'b0;
                end else if (data_go && st_q.armed) begin
                    st_d.armed = 1'b0;
                    if (!flags_any) begin
                        st_d.data  = wdata;
                        st_d.state = S_STORE;
                    end
                end
            end
            S_FETCH: begin
                if (mem_done) begin
                    st_d.data  = mem_rdata;
                    st_d.armed = 1'b1;
                    st_d.state = S_IDLE;
                end
            end
            S_STORE: begin
                if (mem_done) st_d.state = S_IDLE;
            end
            default: st_d.state = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{state: S_IDLE, addr: '0, data: '0, armed: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign addr_q    = st_q.addr;
    assign data_q    = st_q.data;
    assign armed     = st_q.armed;
    assign busy      = st_q.state != S_IDLE;
    assign mem_req   = st_q.state != S_IDLE;
    assign mem_we    = st_q.state == S_STORE;
    assign mem_addr  = st_q.addr;
    assign mem_wdata = st_q.data;

    // R1: a request is held steady until the memory answers
    p_req_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_done) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));
    // R8: a store only starts when no watch flag is set
    p_store_clean_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(mem_req) && mem_we) |-> !flags_any);
endmodule

// File: rtl/atomreg_unit.sv
module atomreg_unit
    import atomreg_pkg::*;
#(
    parameter int DW = 32,
    parameter int AW = 16,
    parameter int OW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_sel,
    input  logic          reg_wr,
    input  logic [OW-1:0] reg_addr,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic          mem_done,
    input  logic [DW-1:0] mem_rdata,
    input  logic          mem_err,
    input  logic          snoop_valid,
    input  logic [AW-1:0] snoop_addr,
    input  logic          bus_lock,
    input  logic          irq_pend
);
    logic             addr_go, data_go, busy, armed, err_evt, window;
    logic [AW-1:0]    addr_q;
    logic [DW-1:0]    data_q;
    logic [NFLAG-1:0] flags;

    assign window = armed && !data_go;

    atomreg_regif #(.DW(DW), .AW(AW), .OW(OW)) u_regif (
        .reg_sel   (reg_sel),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .busy      (busy),
        .addr_q    (addr_q),
        .data_q    (data_q),
        .flags     (flags),
        .addr_go   (addr_go),
        .data_go   (data_go),
        .reg_rdata (reg_rdata)
    );

    atomreg_seq #(.AW(AW), .DW(DW)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr_go   (addr_go),
        .data_go   (data_go),
        .wdata     (reg_wdata),
        .flags_any (|flags),
        .mem_done  (mem_done),
        .mem_rdata (mem_rdata),
        .mem_err   (mem_err),
        .addr_q    (addr_q),
        .data_q    (data_q),
        .busy      (busy),
        .armed     (armed),
        .err_evt   (err_evt),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata)
    );

    atomreg_watch #(.AW(AW)) u_watch (
        .clk         (clk),
        .rst_n       (rst_n),
        .clr         (addr_go),
        .window      (window),
        .held_addr   (addr_q),
        .snoop_valid (snoop_valid),
        .snoop_addr  (snoop_addr),
        .bus_lock    (bus_lock),
        .irq_pend    (irq_pend),
        .err_evt     (err_evt),
        .flags       (flags)
    );

    // R2: an accepted address write leaves all watch flags clear
    p_addr_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_sel && reg_wr && reg_addr == OW'(OFS_ADDR) && !busy) |=> (flags == '0));
    // R9: a data write with nothing fetched starts no transfer
    p_idle_ignore_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_sel && reg_wr && reg_addr == OW'(OFS_DATA) && !busy && !armed) |=> !mem_req);
    // R3: every memory address is word aligned
    p_aligned_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_addr[1:0] == 2'b00));
endmodule

// File: tb/atomreg_unit_bench.sv
module atomreg_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_sel = 1'b0, reg_wr = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mem_req, mem_we;
    logic [15:0] mem_addr;
    logic [31:0] mem_wdata;
    logic        mem_done = 1'b0, mem_err = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        snoop_valid = 1'b0, bus_lock = 1'b0, irq_pend = 1'b0;
    logic [15:0] snoop_addr = '0;

    int total = 0, bad = 0, wr_count = 0, lat = 0;
    logic err_fetch = 1'b0, err_store = 1'b0;
    logic [31:0] mem_m [8];
    logic [31:0] mem_ref [8];

    always #10 clk = ~clk;

    atomreg_unit u_atomreg_unit (
        .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_done(mem_done), .mem_rdata(mem_rdata),
        .mem_err(mem_err), .snoop_valid(snoop_valid), .snoop_addr(snoop_addr),
        .bus_lock(bus_lock), .irq_pend(irq_pend)
    );

    // memory model: answers two negedges after a request is seen
    always @(negedge clk) begin
        if (mem_done) begin
            mem_done = 1'b0;
            mem_err  = 1'b0;
        end else if (mem_req) begin
            if (lat == 1) begin
                lat      = 0;
                mem_done = 1'b1;
                if (mem_we) begin
                    wr_count++;
                    mem_err = err_store;
                    if (!err_store) mem_m[mem_addr[4:2]] = mem_wdata;
                end else begin
                    mem_err   = err_fetch;
                    mem_rdata = mem_m[mem_addr[4:2]];
                end
            end else begin
                lat++;
            end
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [3:0] ofs, output logic [31:0] v);
        reg_addr = ofs;
        #1 v = reg_rdata;
    endtask

    task automatic wr(input logic [3:0] ofs, input logic [31:0] v);
        @(negedge clk);
        #2;
        reg_sel = 1'b1; reg_wr = 1'b1; reg_addr = ofs; reg_wdata = v;
        @(negedge clk);
        #2;
        reg_sel = 1'b0; reg_wr = 1'b0;
    endtask

    task automatic wait_idle;
        logic [31:0] s;
        for (int i = 0; i < 50; i++) begin
            rd(4'h8, s);
            if (!s[4]) return;
            @(negedge clk);
            #2;
        end
        chk("R1 busy stuck", 32'h1, 32'h0);
    endtask

    task automatic one_op(input int a, input int sc);
        logic [31:0] v, oldv, newv, expf;
        int w0;
        logic stores;
        err_fetch = (sc == 5);
        err_store = (sc == 6);
        oldv = mem_ref[a];
        newv = oldv + 32'(sc) + 1;
        expf = (sc == 1) ? 32'h1 : (sc == 3) ? 32'h2 : (sc == 4) ? 32'h4 :
               (sc == 5 || sc == 6) ? 32'h8 : (sc == 7) ? 32'h7 : 32'h0;
        stores = (sc == 0 || sc == 2 || sc == 6);
        wr(4'h0, 32'(a * 4 + (a % 4)));
        rd(4'h8, v);
        chk("R1 busy after address write", v & 32'h10, 32'h10);
        wait_idle();
        rd(4'h0, v); chk("R3/R11 aligned address readback", v, 32'(a * 4));
        rd(4'h4, v); chk("R1 fetched data", v, oldv);
        rd(4'h8, v); chk("R2 flags after fetch", v, (sc == 5) ? 32'h8 : 32'h0);
        @(negedge clk);
        #2;
        if (sc == 1 || sc == 7) begin snoop_valid = 1'b1; snoop_addr = 16'(a * 4 + 1); end
        if (sc == 2) begin snoop_valid = 1'b1; snoop_addr = 16'(((a + 1) % 8) * 4); end
        if (sc == 3 || sc == 7) bus_lock = 1'b1;
        if (sc == 4 || sc == 7) irq_pend = 1'b1;
        @(negedge clk);
        #2;
        snoop_valid = 1'b0; bus_lock = 1'b0; irq_pend = 1'b0;
        w0 = wr_count;
        wr(4'h4, newv);
        wait_idle();
        rd(4'h8, v); chk($sformatf("R4/R5/R6/R7 flags scenario %0d", sc), v, expf);
        chk("R3/R8 memory writes issued", 32'(wr_count - w0), stores ? 32'h1 : 32'h0);
        rd(4'h4, v); chk("R8 data register", v, stores ? newv : oldv);
        if (sc == 0 || sc == 2) mem_ref[a] = newv;
        chk("R3/R7 memory content", mem_m[a], mem_ref[a]);
        err_fetch = 1'b0;
        err_store = 1'b0;
    endtask

    initial begin
        #(20ns * 100000);
        bad++; total++;
        $display("FAIL watchdog expired actual=%0d expected=0", 1);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] v;
        int w0;
        for (int i = 0; i < 8; i++) begin
            mem_m[i]   = 32'h1000_0000 + 32'(i) * 32'h0101;
            mem_ref[i] = mem_m[i];
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #2;
        rd(4'h8, v); chk("R11 reset status", v, 32'h0);
        rd(4'h0, v); chk("R11 reset address", v, 32'h0);
        rd(4'h4, v); chk("R11 reset data", v, 32'h0);
        chk("R1 no request at reset", 32'(mem_req), 32'h0);
        // R9: data write with nothing fetched
        w0 = wr_count;
        wr(4'h4, 32'h5555_AAAA);
        repeat (5) @(negedge clk);
        #2;
        chk("R9 no write without fetch", 32'(wr_count - w0), 32'h0);
        rd(4'h4, v); chk("R9 data unchanged", v, 32'h0);
        rd(4'h8, v); chk("R9 idle after ignored write", v, 32'h0);
        // sweep all words against all hazards
        for (int a = 0; a < 8; a++)
            for (int sc = 0; sc < 8; sc++)
                one_op(a, sc);
        // R9: a second data write after a store attempt is ignored
        one_op(3, 0);
        w0 = wr_count;
        wr(4'h4, 32'hDEAD_0001);
        repeat (5) @(negedge clk);
        #2;
        chk("R9 second data write ignored", 32'(wr_count - w0), 32'h0);
        rd(4'h4, v); chk("R9 data kept", v, mem_ref[3]);
        // R10: writes while busy are ignored
        @(negedge clk);
        #2;
        reg_sel = 1'b1; reg_wr = 1'b1; reg_addr = 4'h0; reg_wdata = 32'h8;
        @(negedge clk);
        #2;
        reg_wdata = 32'h10;
        @(negedge clk);
        #2;
        reg_addr = 4'h4; reg_wdata = 32'hBAD0_BAD0;
        @(negedge clk);
        #2;
        reg_sel = 1'b0; reg_wr = 1'b0;
        wait_idle();
        rd(4'h0, v); chk("R10 address held", v, 32'h8);
        rd(4'h4, v); chk("R10 data is fetched word", v, mem_ref[2]);
        // R11: status writes have no effect
        one_op(5, 4);
        wr(4'h8, 32'h0);
        repeat (2) @(negedge clk);
        #2;
        rd(4'h8, v); chk("R11 status write ignored", v, 32'h4);
        rd(4'hC, v); chk("R11 unused offset reads zero", v, 32'h0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule